// File: doc/BRIEF.md
# Exponential Backoff Retry Controller

This block sets how long a requester waits before it retries an atomic compare-and-swap that keeps losing to competing requesters. It holds a backoff level. The level returns to one when a new atomic operation begins or when an attempt succeeds. Each reported failure first sends one pause request to an external pause unit. The requested length is the current level multiplied by 128. The level then doubles, but only once the pause unit reports that the wait has finished. Doubling stops after the level passes a fixed limit, so the level settles at twice that limit.

While a pause is outstanding the controller shows itself busy, and it ignores any further failure reports. A build parameter can disable the block for single-threaded builds. In that case failures produce no pause and the level never grows.

Top module: `backoff_ctrl`

## Requirements
- R1: After reset, busy and pause_valid are 0, pause_cycles is 0, and the backoff level is 1, so the first accepted failure requests 128 cycles.
- R2: An op_fail seen while busy is 0 and neither op_start nor op_success is high raises pause_valid and busy on the next cycle.
- R3: The pause_cycles value issued for a failure is the level held before that failure, shifted left by 7 (128 cycles per unit), issued as one request.
- R4: The level doubles when pause_done arrives while busy, but only if the level is at most 4096. The issued lengths therefore run 128, 256, ..., 1048576 and then repeat 1048576.
- R5: pause_cycles holds its value while busy is 1 and also after the pause ends, until the next accepted failure.
- R6: An op_fail that arrives while busy is 1 is ignored. It raises no pause_valid and it does not change pause_cycles or the level.
- R7: op_start or op_success returns the level to 1, clears busy and pause_valid, and takes priority over op_fail and pause_done in the same cycle.
- R8: A pause_done that arrives while busy is 0 has no effect on the level.
- R9: With ENABLE set to 0, busy and pause_valid stay 0 whatever the inputs do.
- R10: pause_valid is high for exactly one cycle per accepted failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | A new atomic operation begins; resets the level |
| op_fail | input | 1 | The current attempt failed; asks for a pause |
| op_success | input | 1 | The attempt succeeded; resets the level and ends busy |
| pause_done | input | 1 | The pause unit has finished the requested wait |
| pause_valid | output | 1 | One-cycle pulse that issues a pause request |
| pause_cycles | output | 21 | Requested wait in cycles, the level times 128 |
| busy | output | 1 | A pause is outstanding |

## Verification
The assertions assume that op_fail, op_start, op_success and pause_done are single-bit levels sampled at the clock edge. They also assume that the pause unit may raise pause_done at any time, including when nothing is outstanding. The growth assertions are guarded so that they rely only on pause_done arriving while busy. The stimulus deliberately breaks the usual protocol: it sends failures while busy, completions while idle, and clears in the same cycle as a failure or completion. This checks that the guarded properties and the bench model agree on which input wins.

// File: rtl/backoff_pkg.sv
package backoff_pkg;

  // Level after one finished pause: doubles until it passes the limit.
  function automatic int unsigned grow_level(input int unsigned cur, input int unsigned lim);
    if (cur > lim) return cur;
    return cur << 1;
  endfunction

  // Blocked cycles requested for a given level.
  function automatic int unsigned level_to_cycles(input int unsigned lvl, input int unsigned sh);
    return lvl << sh;
  endfunction

endpackage

// File: rtl/backoff_level_reg.sv
module backoff_level_reg
  import backoff_pkg::*;
#(
  parameter int LIMIT = 4096,
  parameter int LVL_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             grow,
  output logic [LVL_W-1:0] level
);

  logic [LVL_W-1:0] level_next;

  always_comb begin
    level_next = level;
    if (clear)     level_next = LVL_W'(1);
    else if (grow) level_next = LVL_W'(grow_level(int'(level), LIMIT));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) level <= LVL_W'(1);
    else        level <= level_next;
  end

  // R4: growth doubles while at or below the limit
  a_r4_double: assert property (@(posedge clk) disable iff (!rst_n)
    (grow && !clear && int'(level) <= LIMIT) |=> int'(level) == 2 * int'($past(level)));
  // R4: saturation above the limit
  a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (grow && !clear && int'(level) > LIMIT) |=> $stable(level));
  // R7: clear returns level to one
  a_r7_clear_level: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> level == LVL_W'(1));
  // R4: level never exceeds twice the limit and is never zero
  a_r4_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(level) <= 2 * LIMIT) && (level != '0));

endmodule

// File: rtl/backoff_pause_issuer.sv
module backoff_pause_issuer
  import backoff_pkg::*;
#(
  parameter int SHIFT = 7,
  parameter int LVL_W = 14,
  parameter int CYC_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             fail,
  input  logic             done,
  input  logic [LVL_W-1:0] level,
  output logic             grow,
  output logic             pause_valid,
  output logic [CYC_W-1:0] pause_cycles,
  output logic             busy
);

  logic accept_fail;
  logic finish_pause;

  assign accept_fail  = fail && !busy && !clear;
  assign finish_pause = done && busy && !clear;
  assign grow         = finish_pause;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      pause_valid  <= 1'b0;
      pause_cycles <= '0;
    end else begin
      pause_valid <= accept_fail;
      if (clear)             busy <= 1'b0;
      else if (finish_pause) busy <= 1'b0;
      else if (accept_fail)  busy <= 1'b1;
      if (accept_fail)
        pause_cycles <= CYC_W'(level_to_cycles(int'(level), SHIFT));
    end
  end

  // R2: an accepted failure issues a pause and raises busy
  a_r2_issue: assert property (@(posedge clk) disable iff (!rst_n)
    accept_fail |=> (pause_valid && busy));
  // R10: the request is a single-cycle pulse
  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pause_valid |=> !pause_valid);
  // R5: the requested length is steady while waiting
  a_r5_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fail) |=> $stable(pause_cycles));
  // R6: failure while busy raises no request
  a_r6_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && busy) |=> !pause_valid);
  // R7: clear drops busy
  a_r7_clear_busy: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!busy && !pause_valid));

endmodule

// File: rtl/backoff_ctrl.sv
module backoff_ctrl #(
  parameter int LIMIT  = 4096,
  parameter int SHIFT  = 7,
  parameter bit ENABLE = 1'b1,
  localparam int LVL_W = $clog2(LIMIT) + 2,
  localparam int CYC_W = LVL_W + SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_start,
  input  logic             op_fail,
  input  logic             op_success,
  input  logic             pause_done,
  output logic             pause_valid,
  output logic [CYC_W-1:0] pause_cycles,
  output logic             busy
);

  generate
    if (ENABLE) begin : g_active
      logic             clear_evt;
      logic             grow_evt;
      logic [LVL_W-1:0] level;

      assign clear_evt = op_start || op_success;

      backoff_level_reg #(.LIMIT(LIMIT), .LVL_W(LVL_W)) u_level (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear_evt),
        .grow  (grow_evt),
        .level (level)
      );

      backoff_pause_issuer #(.SHIFT(SHIFT), .LVL_W(LVL_W), .CYC_W(CYC_W)) u_issue (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (clear_evt),
        .fail         (op_fail),
        .done         (pause_done),
        .level        (level),
        .grow         (grow_evt),
        .pause_valid  (pause_valid),
        .pause_cycles (pause_cycles),
        .busy         (busy)
      );

      // R3: an issued length is always a whole multiple of the unit
      a_r3_unit_multiple: assert property (@(posedge clk) disable iff (!rst_n)
        pause_valid |-> (pause_cycles[SHIFT-1:0] == '0 && pause_cycles != '0));
    end else begin : g_off
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst_n, op_start, op_fail, op_success, pause_done};
      assign pause_valid   = 1'b0;
      assign pause_cycles  = '0;
      assign busy          = 1'b0;
    end
  endgenerate

endmodule

// File: tb/backoff_ctrl_test.sv
`timescale 1ns/1ps
module backoff_ctrl_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_start = 1'b0, op_fail = 1'b0, op_success = 1'b0, pause_done = 1'b0;
  logic        pause_valid, busy;
  logic [20:0] pause_cycles;
  logic        off_valid, off_busy;
  logic [20:0] off_cycles;

  int total = 0;
  int bad = 0;

  // reference model state
  int  m_level = 1;
  bit  m_busy = 0;
  bit  m_valid = 0;
  int  m_cycles = 0;

  always #2 clk = ~clk;

  backoff_ctrl uut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_fail(op_fail),
    .op_success(op_success), .pause_done(pause_done),
    .pause_valid(pause_valid), .pause_cycles(pause_cycles), .busy(busy));

  backoff_ctrl #(.ENABLE(1'b0)) uut_off (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_fail(op_fail),
    .op_success(op_success), .pause_done(pause_done),
    .pause_valid(off_valid), .pause_cycles(off_cycles), .busy(off_busy));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_step(input bit s, input bit f, input bit ok, input bit d);
    bit nv = 0;
    if (s || ok) begin
      m_level = 1; m_busy = 0;
    end else if (m_busy && d) begin
      m_busy = 0;
      if (m_level <= 4096) m_level = m_level * 2;
    end else if (!m_busy && f) begin
      m_busy = 1; nv = 1; m_cycles = m_level * 128;
    end
    m_valid = nv;
  endtask

  // drive one cycle, advance the model, compare every output
  task automatic cycle(input string req, input bit s, input bit f, input bit ok, input bit d);
    @(negedge clk);
    op_start = s; op_fail = f; op_success = ok; pause_done = d;
    @(posedge clk);
    model_step(s, f, ok, d);
    #1;
    check({req, " valid"},  int'(pause_valid),  int'(m_valid));
    check({req, " busy"},   int'(busy),         int'(m_busy));
    check({req, " cycles"}, int'(pause_cycles), m_cycles);
    check("R9 off valid", int'(off_valid), 0);
    check("R9 off busy",  int'(off_busy),  0);
  endtask

  initial begin : watchdog
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1 busy",   int'(busy), 0);
    check("R1 valid",  int'(pause_valid), 0);
    check("R1 cycles", int'(pause_cycles), 0);

    // R1/R3: first failure requests 128
    cycle("R2", 0, 1, 0, 0);
    check("R3 first length", int'(pause_cycles), 128);
    cycle("R10", 0, 0, 0, 0);
    check("R10 pulse low", int'(pause_valid), 0);
    // R6: fail while busy
    cycle("R6", 0, 1, 0, 0);
    check("R6 no pulse", int'(pause_valid), 0);
    cycle("R5", 0, 0, 0, 0);
    cycle("R4", 0, 0, 0, 1);
    // R8: stray completions while idle
    cycle("R8", 0, 0, 0, 1);
    cycle("R8", 0, 0, 0, 1);
    cycle("R8", 0, 1, 0, 0);
    check("R8 level unchanged", int'(pause_cycles), 256);
    cycle("R4", 0, 0, 0, 1);

    // R4: walk to saturation
    for (int i = 0; i < 16; i++) begin
      cycle("R2", 0, 1, 0, 0);
      cycle("R5", 0, 0, 0, 0);
      cycle("R4", 0, 1, 0, 1);
    end
    cycle("R4", 0, 1, 0, 0);
    check("R4 saturated length", int'(pause_cycles), 1048576);

    // R7: success mid-pause, same cycle as done
    cycle("R7", 0, 0, 1, 1);
    check("R7 busy cleared", int'(busy), 0);
    cycle("R7", 0, 1, 0, 0);
    check("R7 level one", int'(pause_cycles), 128);
    cycle("R4", 0, 0, 0, 1);
    cycle("R4", 0, 1, 0, 0);
    cycle("R4", 0, 0, 0, 1);
    // R7: start wins over same-cycle fail
    cycle("R7", 1, 1, 0, 0);
    check("R7 start priority", int'(pause_valid), 0);
    cycle("R7", 0, 1, 0, 0);
    check("R7 start reset", int'(pause_cycles), 128);
    cycle("R7", 1, 0, 0, 0);
    for (int i = 0; i < 6; i++) cycle("R9", 0, 1, 0, (i % 2) == 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule